// File: doc/BRIEF.md
# State-Partition Novelty Coverage Monitor

This block observes the fault-free flip-flop state of a design under test on every cycle that a sample strobe is high. The state vector is cut into equal, disjoint groups of adjacent bits, and each group keeps its own visited bitmap with one bit for every value that group can take. A sample is judged novel when at least one group shows a value it has not held since the last clear.

For every accepted sample the block reports how many groups saw a fresh value, so a sample that opens up two groups at once ranks above one that opens up a single group. It also raises a single novelty flag and keeps a running, saturating count of novel samples. A stimulus search engine reads that count as its fitness score. A synchronous clear starts a new measurement without a full reset.

Top module: `state_novelty_monitor`

## Requirements
- R1: After reset all outputs are zero and every visited bitmap is empty, so the first accepted sample reports every group as new.
- R2: Group g is made of state bits [GROUP_W*g+GROUP_W-1 : GROUP_W*g]. Each group is tracked on its own: a value seen in one group does not count as seen in another.
- R3: new_groups gives the number of groups whose current value was not in their bitmap. It is registered and appears on the clock edge that takes the sample, and it never exceeds NUM_GROUPS.
- R4: novel is 1 exactly when new_groups is non-zero.
- R5: The bitmaps are updated on the same edge that takes the sample, so the same state sampled again on the next cycle is not new.
- R6: new_state_cnt rises by exactly one for each accepted sample that is novel, and otherwise holds its value.
- R7: new_state_cnt saturates at 2^SCORE_W-1 and stays there while novel samples keep arriving.
- R8: On a cycle with sample_vld low, novel and new_groups read 0 after that edge, and neither the bitmaps nor the count change.
- R9: A clear empties all bitmaps and zeroes every output on that edge. It takes priority over a sample in the same cycle, and that sample is not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous clear of bitmaps and outputs |
| sample_vld | input | 1 | Current state_vec is a sample to judge |
| state_vec | input | GROUP_W*NUM_GROUPS | Observed flip-flop state |
| novel | output | 1 | Last sample reached at least one unseen group value |
| new_groups | output | $clog2(NUM_GROUPS+1) | Number of groups with an unseen value in the last sample |
| new_state_cnt | output | SCORE_W | Saturating count of novel samples (fitness score) |

## Verification
Every result is due one edge after the inputs that cause it: novel, new_groups and the count all become visible on the rising edge that takes the sample or clear, and the bitmap change affects the judgement of the very next sample. The bench drives each input on a falling edge and reads the outputs shortly after the following rising edge. Its model is updated once per applied vector, so expected and actual values always refer to the same edge. A second instance with a 3-bit score is used to reach saturation within a short sweep.

// File: rtl/novmon_pkg.sv
// Package: shared default sizes for the novelty monitor.
// Assumes: groups are equal width and cover the state vector exactly.
package novmon_pkg;
    localparam int unsigned GROUP_W_DEF    = 4;
    localparam int unsigned NUM_GROUPS_DEF = 4;
    localparam int unsigned SCORE_W_DEF    = 16;
endpackage

// File: rtl/nov_group_tracker.sv
// Module: visited bitmap for one state group.
// It flags a valid value that the group has never held, and marks that
// value as visited on the same edge. Assumes the caller gates clear
// priority, and that clear wins over a sample.
module nov_group_tracker #(
    parameter int unsigned GROUP_W = 4,
    localparam int unsigned DEPTH  = 1 << GROUP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               vld,
    input  logic [GROUP_W-1:0] val,
    output logic               is_new
);
    logic [DEPTH-1:0] seen_q;

    // Purpose: a valid value whose visited bit is clear is new.
    always_comb begin
        is_new = vld && !seen_q[val];
    end

    // Purpose: empty the bitmap on reset or clear, else mark sampled values.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seen_q <= '0;
        end else if (vld) begin
            seen_q[val] <= 1'b1;
        end
    end

    // R5: a sampled value is marked visited right after its edge
    p_mark_visited_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !clr) |=> seen_q[$past(val)]);

    // R9: clear leaves an empty bitmap
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (seen_q == '0));
endmodule

// File: rtl/nov_tally.sv
// Module: counts the set bits in a flag vector.
// Assumes NUM fits in the output width given by $clog2(NUM+1).
module nov_tally #(
    parameter int unsigned NUM = 4,
    localparam int unsigned CW = $clog2(NUM + 1)
) (
    input  logic [NUM-1:0] flags,
    output logic [CW-1:0]  total
);
    // Purpose: add up the flags one by one.
    always_comb begin
        total = '0;
        for (int i = 0; i < NUM; i++) begin
            total = total + CW'(flags[i]);
        end
    end
endmodule

// File: rtl/nov_score.sv
// Module: saturating counter of novel samples.
// Assumes inc is already qualified by sample valid; clear wins over inc.
module nov_score #(
    parameter int unsigned SCORE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               inc,
    output logic [SCORE_W-1:0] cnt
);
    localparam logic [SCORE_W-1:0] TOP = '1;

    // Purpose: zero on reset or clear, else step up until the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: the count only ever moves by one, or to zero on clear
    p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr) && (cnt != $past(cnt))) |-> (cnt == $past(cnt) + 1'b1));

    // R7: a saturated count holds until clear
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == TOP) && !clr) |=> (cnt == TOP));
endmodule

// File: rtl/state_novelty_monitor.sv
// Module: top of the state-partition novelty monitor.
// It splits the state into NUM_GROUPS groups of GROUP_W bits, judges each
// against its own visited bitmap, and reports the number of new groups, a
// novelty flag and a saturating score. Assumes clear has priority over a
// sample and that only fault-free state is presented.
module state_novelty_monitor
    import novmon_pkg::*;
#(
    parameter int unsigned GROUP_W    = GROUP_W_DEF,
    parameter int unsigned NUM_GROUPS = NUM_GROUPS_DEF,
    parameter int unsigned SCORE_W    = SCORE_W_DEF,
    localparam int unsigned STATE_W   = GROUP_W * NUM_GROUPS,
    localparam int unsigned GCNT_W    = $clog2(NUM_GROUPS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               sample_vld,
    input  logic [STATE_W-1:0] state_vec,
    output logic               novel,
    output logic [GCNT_W-1:0]  new_groups,
    output logic [SCORE_W-1:0] new_state_cnt
);
    logic [NUM_GROUPS-1:0] hit_new;
    logic [GCNT_W-1:0]     hit_total;
    logic                  any_new;

    // One visited bitmap per group slice.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        nov_group_tracker #(.GROUP_W(GROUP_W)) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clear),
            .vld    (sample_vld),
            .val    (state_vec[g*GROUP_W +: GROUP_W]),
            .is_new (hit_new[g])
        );
    end

    nov_tally #(.NUM(NUM_GROUPS)) u_tally (
        .flags (hit_new),
        .total (hit_total)
    );

    // Purpose: a sample is novel when any group saw a fresh value.
    always_comb begin
        any_new = |hit_new;
    end

    nov_score #(.SCORE_W(SCORE_W)) u_score (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear),
        .inc   (any_new),
        .cnt   (new_state_cnt)
    );

    // Purpose: register the per-sample results, quiet when idle or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !sample_vld) begin
            novel      <= 1'b0;
            new_groups <= '0;
        end else begin
            novel      <= any_new;
            new_groups <= hit_total;
        end
    end

    // R3: never more new groups than groups
    p_group_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        new_groups <= GCNT_W'(NUM_GROUPS));

    // R4: flag agrees with the group count
    p_flag_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
        novel == (new_groups != '0));

    // R5: the same state sampled twice in a row is not new the second time
    p_repeat_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && !clear && $past(sample_vld) && !$past(clear)
         && (state_vec == $past(state_vec))) |=> !novel);

    // R6: a novel sample below the top bumps the score by one
    p_score_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (novel && ($past(new_state_cnt) != '1))
        |-> (new_state_cnt == $past(new_state_cnt) + 1'b1));

    // R8: an idle cycle leaves quiet outputs and a steady score
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_vld && !clear) |=> (!novel && (new_groups == '0) && $stable(new_state_cnt)));
endmodule

// File: tb/tb_state_novelty_monitor.sv
module tb_state_novelty_monitor;
    localparam int unsigned GW = 4;
    localparam int unsigned NG = 4;
    localparam int unsigned SW = 16;
    localparam int unsigned SAT_W = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        sample_vld = 1'b0;
    logic [15:0] state_vec = '0;
    logic        novel, novel_s;
    logic [2:0]  new_groups, new_groups_s;
    logic [SW-1:0]    cnt;
    logic [SAT_W-1:0] cnt_s;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // expected model
    bit [15:0] m_seen [NG];
    int m_cnt = 0;
    int m_cnt_s = 0;

    always #4 clk = ~clk;

    state_novelty_monitor #(.GROUP_W(GW), .NUM_GROUPS(NG), .SCORE_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .sample_vld(sample_vld),
        .state_vec(state_vec), .novel(novel), .new_groups(new_groups),
        .new_state_cnt(cnt));

    state_novelty_monitor #(.GROUP_W(GW), .NUM_GROUPS(NG), .SCORE_W(SAT_W)) dut_sat (
        .clk(clk), .rst_n(rst_n), .clear(clear), .sample_vld(sample_vld),
        .state_vec(state_vec), .novel(novel_s), .new_groups(new_groups_s),
        .new_state_cnt(cnt_s));

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, check after the edge.
    task automatic apply(input bit vld, input bit clr, input logic [15:0] st, input string req);
        int n_exp = 0;
        @(negedge clk);
        sample_vld = vld;
        clear = clr;
        state_vec = st;
        if (clr) begin
            for (int g = 0; g < NG; g++) m_seen[g] = '0;
            m_cnt = 0;
            m_cnt_s = 0;
        end else if (vld) begin
            for (int g = 0; g < NG; g++) begin
                int v = int'(st[g*GW +: GW]);
                if (!m_seen[g][v]) n_exp++;
                m_seen[g][v] = 1'b1;
            end
            if (n_exp > 0) begin
                if (m_cnt < (1 << SW) - 1) m_cnt++;
                if (m_cnt_s < (1 << SAT_W) - 1) m_cnt_s++;
            end
        end
        @(posedge clk);
        #2;
        check(req, "new_groups", int'(new_groups), n_exp);
        check(req, "novel", int'(novel), int'(n_exp > 0));
        check(req, "new_state_cnt", int'(cnt), m_cnt);
        check(req, "sat new_state_cnt", int'(cnt_s), m_cnt_s);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R1", "novel at reset", int'(novel), 0);
        check("R1", "new_groups at reset", int'(new_groups), 0);
        check("R1", "count at reset", int'(cnt), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int g = 0; g < NG; g++) m_seen[g] = '0;
        m_cnt = 0;
        m_cnt_s = 0;
        apply(1'b1, 1'b0, 16'h0000, "R1");
    endtask

    task automatic t_repeat;
        apply(1'b1, 1'b0, 16'h0000, "R5");
        apply(1'b1, 1'b0, 16'h0000, "R5");
    endtask

    task automatic t_groups;
        apply(1'b1, 1'b0, 16'h0001, "R3");
        apply(1'b1, 1'b0, 16'h0110, "R2");
        apply(1'b1, 1'b0, 16'h1000, "R2");
        apply(1'b1, 1'b0, 16'h2233, "R4");
        apply(1'b1, 1'b0, 16'h0101, "R6");
    endtask

    task automatic t_idle;
        apply(1'b0, 1'b0, 16'hFFFF, "R8");
        apply(1'b0, 1'b0, 16'hEEEE, "R8");
        apply(1'b1, 1'b0, 16'hFFFF, "R8");
    endtask

    task automatic t_clear;
        apply(1'b1, 1'b1, 16'h5555, "R9");
        apply(1'b1, 1'b0, 16'h0000, "R9");
        apply(1'b1, 1'b0, 16'h5555, "R9");
    endtask

    task automatic t_saturate;
        for (int k = 0; k < 16; k++) begin
            apply(1'b1, 1'b0, {4{4'(k)}}, "R7");
        end
        apply(1'b1, 1'b0, 16'h4321, "R7");
    endtask

    initial begin
        t_reset();
        t_repeat();
        t_groups();
        t_idle();
        t_clear();
        t_saturate();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule